// File: doc/BRIEF.md
# Two-Bank Edge/Level Interrupt Controller

This block gathers 64 interrupt source lines into two banks of 32 and drives one interrupt request towards a processor. Each bank has its own latched event bits, its own enable bits, a write-one-to-clear acknowledge register, and a read-only view of the live, synchronized input lines. A fixed per-bank mask, chosen by parameter, marks some sources as level-triggered. Those sources feed the pending logic straight from the line state. All other sources are edge-triggered: each latches a rising edge into its event bit, but only while its enable bit is set.

Software sees the controller through a simple synchronous register bus made of an address, a write strobe, write data and registered read data. A read-only vector register gives the number of the highest pending source. The bank holding the upper source numbers is searched first, and within a bank the highest bit wins. The same vector is also available on a port.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: Source n belongs to bank n/32 at bit n mod 32. Bank 0 (sources 0..31) has its register group at byte offset 0x20 and bank 1 (sources 32..63) at 0x10. Within a group, the event register is at +0x0, enable at +0x4, ack at +0x8 and level at +0xC. The vector register is at 0x00. Every other address reads 0.
- R2: An edge source with its enable bit at 1 latches its event bit on a rising edge of its line. When the line rises just before clock edge E1, the event bit is set at E3 and irq_o goes high at E4.
- R3: A rising edge on an edge source whose enable bit is 0 leaves its event bit at 0.
- R4: Setting an enable bit while that source's line is already high sets no event bit and raises no request.
- R5: Writing the ack register clears each event bit written as 1 and leaves the bits written as 0 unchanged. The ack register reads as 0.
- R6: If an ack write to a bit and a new rising edge on that bit are sampled at the same clock edge, the event bit stays set.
- R7: The level mask is 0x3FF00000 (bits 20..29) when LVL_WIDE is 1 for that bank and 0x1FF00000 (bits 20..28) otherwise. The defaults are wide for bank 0 and narrow for bank 1. A masked, enabled source is pending while its line is high, stops being pending when the line falls with no ack, and never sets its event bit.
- R8: The level register of a bank reads the synchronized state of all 32 of its lines.
- R9: The pending set is (event OR (line AND level mask)) AND enable. irq_o is the OR of all 64 pending bits, registered one cycle after the pending set.
- R10: The vector is the 6-bit number of the winning pending source, with bank 1 searched before bank 0 and the highest bit winning within a bank. It reads 0x80 when nothing is pending.
- R11: After reset, all event and enable bits are 0 and irq_o is 0. Writing 0 to a bank's enable register stops every source in that bank from requesting.
- R12: bus_rdata returns, one clock after the address is presented, the register at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Asynchronous interrupt source lines, bit n is source n |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Winning source number, bit 7 set when none is pending |

## Verification
A wrong event or enable bit shows up at the ports within one clock of the next register read. It also appears on irq_o and vec_o one or two cycles after the pending set changes. A lost edge shows up as an event register that reads 0 when the stimulus model expects 1. A spurious latch, such as one caused by enabling a source whose line is already high or by a level source, shows up as an unexpected 1 and a request that should not exist. Priority faults show up on the vector when sources in both banks are pending at once.

// File: rtl/dbic_pkg.sv
package dbic_pkg;
    localparam int SRC_PER_BANK = 32;
    localparam int NUM_BANKS    = 2;
    localparam int NUM_SRC      = SRC_PER_BANK * NUM_BANKS;
    localparam int IDX_W        = $clog2(NUM_SRC);
    localparam int VEC_W        = 8;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 6;

    typedef enum logic [1:0] {
        SEL_EVENT  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_ACK    = 2'd2,
        SEL_LEVEL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     bank_hit;
        logic     vec_hit;
        logic     bank;
        reg_sel_e sel;
    } bus_dec_t;

    function automatic logic [SRC_PER_BANK-1:0] level_mask(input bit wide);
        logic [SRC_PER_BANK-1:0] m;
        m = '0;
        for (int i = 20; i <= 29; i++) begin
            if (i < SRC_PER_BANK && (wide || i != 29)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic bus_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        bus_dec_t d;
        int grp;
        d = '{bank_hit: 1'b0, vec_hit: 1'b0, bank: 1'b0, sel: SEL_EVENT};
        grp = int'(a[ADDR_W-1:4]);
        if (a[1:0] == 2'b00) begin
            if (grp == 0 && a[3:2] == 2'b00) begin
                d.vec_hit = 1'b1;
            end else if (grp >= 1 && grp <= NUM_BANKS) begin
                d.bank_hit = 1'b1;
                d.bank     = 1'(NUM_BANKS - grp);
                d.sel      = reg_sel_e'(a[3:2]);
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/dbic_sync.sv
module dbic_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/dbic_bank.sv
module dbic_bank #(
    parameter int         W     = 32,
    parameter logic [W-1:0] LMASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] line_s,
    input  logic         en_we,
    input  logic         ack_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] event_q,
    output logic [W-1:0] enable_q,
    output logic [W-1:0] pending
);
    logic [W-1:0] line_d;
    logic [W-1:0] rise;
    logic [W-1:0] ack_bits;

    assign rise     = line_s & ~line_d & enable_q & ~LMASK;
    assign ack_bits = ack_we ? wdata : '0;
    assign pending  = (event_q | (line_s & LMASK)) & enable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_d   <= '0;
            event_q  <= '0;
            enable_q <= '0;
        end else begin
            line_d  <= line_s;
            event_q <= (event_q & ~ack_bits) | rise;
            if (en_we) enable_q <= wdata;
        end
    end

    // R5: acked bits without a coincident edge are clear afterwards
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
        ack_we |=> ((event_q & $past(wdata & ~rise)) == '0));

    // R3: no event bit appears where the enable was 0
    p_no_latch_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((event_q & ~$past(event_q) & ~$past(enable_q)) == '0));

    // R11: a zero enable write silences the bank
    p_enable_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (en_we && wdata == '0) |=> (pending == '0));

    // R7: level sources never hold an event bit
    p_level_no_event_r7: assert property (@(posedge clk) disable iff (rst)
        ((event_q & LMASK) == '0));
endmodule

// File: rtl/dbic_prio.sv
module dbic_prio #(
    parameter int N     = 64,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     pend,
    output logic             none,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx  = '0;
        none = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (pend[i]) begin
                idx  = IDX_W'(i);
                none = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl
    import dbic_pkg::*;
#(
    parameter logic [NUM_BANKS-1:0] LVL_WIDE = 2'b01
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   irq_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_o,
    output logic [VEC_W-1:0]     vec_o
);
    localparam int PAD_W = VEC_W - 1 - IDX_W;

    logic [NUM_SRC-1:0]      line_s;
    logic [NUM_SRC-1:0]      pend_all;
    logic [NUM_SRC-1:0]      event_all;
    logic [NUM_SRC-1:0]      enable_all;
    logic                    prio_none;
    logic [IDX_W-1:0]        prio_idx;
    bus_dec_t                dec;
    logic [DATA_W-1:0]       rd_next;

    assign dec = decode_addr(bus_addr);

    dbic_sync #(.W(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (irq_in),
        .q_sync  (line_s)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel_bank;
        assign sel_bank = bus_we && dec.bank_hit && (int'(dec.bank) == b);

        dbic_bank #(
            .W     (SRC_PER_BANK),
            .LMASK (level_mask(LVL_WIDE[b]))
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .line_s   (line_s[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .en_we    (sel_bank && dec.sel == SEL_ENABLE),
            .ack_we   (sel_bank && dec.sel == SEL_ACK),
            .wdata    (bus_wdata[SRC_PER_BANK-1:0]),
            .event_q  (event_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .enable_q (enable_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .pending  (pend_all[b*SRC_PER_BANK +: SRC_PER_BANK])
        );
    end

    dbic_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .pend (pend_all),
        .none (prio_none),
        .idx  (prio_idx)
    );

    assign vec_o = {prio_none, {PAD_W{1'b0}}, prio_idx};

    always_comb begin
        rd_next = '0;
        if (dec.vec_hit) begin
            rd_next = DATA_W'(vec_o);
        end else if (dec.bank_hit) begin
            unique case (dec.sel)
                SEL_EVENT:  rd_next = DATA_W'(event_all[dec.bank*SRC_PER_BANK +: SRC_PER_BANK]);
                SEL_ENABLE: rd_next = DATA_W'(enable_all[dec.bank*SRC_PER_BANK +: SRC_PER_BANK]);
                SEL_ACK:    rd_next = '0;
                SEL_LEVEL:  rd_next = DATA_W'(line_s[dec.bank*SRC_PER_BANK +: SRC_PER_BANK]);
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o     <= 1'b0;
            bus_rdata <= '0;
        end else begin
            irq_o     <= |pend_all;
            bus_rdata <= rd_next;
        end
    end

    // R9: request follows the encoder's view of the pending set one cycle later
    p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
        !prio_none |=> irq_o);
    p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
        prio_none |=> !irq_o);

    // R11: the request is low right after reset
    p_reset_quiet_r11: assert property (@(posedge clk)
        rst |=> !irq_o);

    // R10: a valid vector is always a source that is enabled
    p_vec_enabled_r10: assert property (@(posedge clk) disable iff (rst)
        !vec_o[VEC_W-1] |-> enable_all[prio_idx]);
endmodule

// File: tb/dual_bank_irq_ctrl_test.sv
module dual_bank_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_in = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic [7:0]  vec_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_en [2];
    logic [31:0] m_ev [2];

    always #4 clk = ~clk;

    dual_bank_irq_ctrl uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .vec_o(vec_o)
    );

    function automatic logic [31:0] lmask(input int b);
        return (b == 0) ? 32'h3FF0_0000 : 32'h1FF0_0000;
    endfunction

    function automatic logic [5:0] base(input int b);
        return 6'h20 - 6'(b * 16);
    endfunction

    function automatic logic [63:0] exp_pend();
        logic [63:0] p;
        for (int b = 0; b < 2; b++)
            p[b*32 +: 32] = (m_ev[b] | (irq_in[b*32 +: 32] & lmask(b))) & m_en[b];
        return p;
    endfunction

    function automatic logic [7:0] exp_vec(input logic [63:0] p);
        for (int i = 63; i >= 0; i--)
            if (p[i]) return 8'(i);
        return 8'h80;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic set_en(input int b, input logic [31:0] v);
        wr(base(b) + 6'h4, v);
        m_en[b] = v;
    endtask

    task automatic ack(input int b, input logic [31:0] v);
        wr(base(b) + 6'h8, v);
        m_ev[b] = m_ev[b] & ~v;
    endtask

    task automatic set_lines(input logic [63:0] v);
        @(negedge clk);
        for (int b = 0; b < 2; b++)
            m_ev[b] = m_ev[b] | (v[b*32 +: 32] & ~irq_in[b*32 +: 32] & m_en[b] & ~lmask(b));
        irq_in = v;
        wait_cyc(6);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        logic [63:0] p;
        p = exp_pend();
        for (int b = 0; b < 2; b++) begin
            rd(base(b), d);          check({tag, " R1 event"}, d, m_ev[b]);
            rd(base(b) + 6'h4, d);   check({tag, " R1 enable"}, d, m_en[b]);
            rd(base(b) + 6'hC, d);   check({tag, " R8 level"}, d, irq_in[b*32 +: 32]);
        end
        rd(6'h00, d);                check({tag, " R10 vector reg"}, d, 64'(exp_vec(p)));
        check({tag, " R10 vec_o"}, vec_o, exp_vec(p));
        check({tag, " R9 irq_o"}, irq_o, |p);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        irq_in = '0;
        m_en[0] = '0; m_en[1] = '0; m_ev[0] = '0; m_ev[1] = '0;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        do_reset();
        check("R11 reset irq_o", irq_o, 0);
        check_all("R11 reset");
        rd(6'h3C, d); check("R1 unmapped read", d, 0);

        // R4: enable while line already high
        set_lines(64'h8);
        set_en(0, 32'h8);
        wait_cyc(6);
        check_all("R4 enable-while-high");
        set_lines(64'h0);

        // R3: edge on a disabled source
        set_lines(64'h1 << 40);
        check_all("R3 disabled edge");
        set_lines(64'h0);

        // R2: exact latency of an edge to irq_o
        set_en(0, 32'h20);
        @(negedge clk);
        irq_in = 64'h20;
        m_ev[0] = 32'h20;
        wait_cyc(3);
        check("R2 irq_o low after E3", irq_o, 0);
        wait_cyc(1);
        check("R2 irq_o high after E4", irq_o, 1);
        check_all("R2 edge latched");

        // R5: ack of zeros keeps, ack of one clears, ack reads 0
        ack(0, 32'h0);
        check_all("R5 ack zero");
        rd(base(0) + 6'h8, d); check("R5 ack reads zero", d, 0);
        ack(0, 32'h20);
        wait_cyc(2);
        check_all("R5 ack clear");

        // R6: ack and new edge at the same clock edge
        set_lines(64'h0);
        set_lines(64'h20);
        set_lines(64'h0);
        @(negedge clk);
        irq_in = 64'h20;
        wait_cyc(2);
        bus_addr = base(0) + 6'h8; bus_wdata = 32'h20; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        wait_cyc(4);
        rd(base(0), d); check("R6 edge beats ack", d, 32'h20);
        ack(0, 32'h20);
        set_lines(64'h0);

        // R7: level source in bank 0, bit 25
        set_en(0, 32'h0200_0000);
        @(negedge clk);
        irq_in = 64'h0200_0000;
        wait_cyc(2);
        check("R7 level irq low after E2", irq_o, 0);
        wait_cyc(1);
        check("R7 level irq high after E3", irq_o, 1);
        check_all("R7 level pending");
        set_lines(64'h0);
        check_all("R7 level released");

        // R7: bit 29 is level in bank 0 (wide) and edge in bank 1 (narrow)
        set_en(0, 32'h2000_0000);
        set_en(1, 32'h2000_0000);
        set_lines((64'h1 << 61) | (64'h1 << 29));
        check_all("R7 mask width");
        set_lines(64'h0);
        check_all("R7 mask width after fall");
        ack(1, 32'h2000_0000);

        // R10: bank 1 low bit beats bank 0 high bit
        set_en(0, 32'h8000_0000);
        set_en(1, 32'h2);
        set_lines((64'h1 << 31) | (64'h1 << 33));
        check_all("R10 priority");
        check("R10 winner is 33", vec_o, 8'd33);

        // R11: zero enable silences the bank
        set_en(1, 32'h0);
        wait_cyc(2);
        check_all("R11 disable bank1");
        set_en(0, 32'h0);
        wait_cyc(2);
        check_all("R11 disable bank0");

        // random phase
        do_reset();
        for (int it = 0; it < 150; it++) begin
            int op;
            op = int'($urandom_range(0, 3));
            case (op)
                0: set_en(int'($urandom_range(0, 1)), $urandom());
                1: set_lines({$urandom(), $urandom()});
                2: set_lines(irq_in & {$urandom(), $urandom()});
                default: ack(int'($urandom_range(0, 1)), $urandom());
            endcase
            wait_cyc(6);
            check_all("R12 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule